// File: doc/BRIEF.md
# Stored Round-Key Generator for a Variable-Size Block Cipher

This block prepares every round key a Rijndael-style cipher core needs before any data is processed. The cipher key and the data block are each 4, 6 or 8 words of 32 bits, and the two sizes may be paired freely. From the pair the block derives the round count, which is the larger word count plus six. It expands the loaded key into Nb times (Nr+1) words, at one word per clock. Every word is kept in an internal array, so no key material has to be rebuilt while data rounds run.

A host writes the cipher key one word at a time, picks the two sizes and pulses `start`. When `done` goes high the whole schedule is resident. The data path then asks for a round index with a direction bit. In the forward direction it gets round key r. In the reverse direction it gets round key Nr−r, so a decryption path can count upward too. The key appears one cycle after the request, as one wide word of up to eight 32-bit slots.

Top module: `keysched_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `busy`, `done` and `rd_valid` are low.
- R2: On the edge that accepts `start`, `nk_code` and `nb_code` are sampled with the codes 0 → 4 words, 1 → 6 words, 2 or 3 → 8 words. From that edge `rounds` shows max(Nk, Nb) + 6.
- R3: `key_we` writes `key_word` into key slot `key_idx`, and byte 0 of the word is bits 31:24. Expanded words 0 to Nk−1 equal key slots 0 to Nk−1.
- R4: For i ≥ Nk, word i = word(i−Nk) XOR t, where t = word(i−1) by default. When i mod Nk = 0, t is the byte substitution of word(i−1) rotated left by one byte, XOR the round constant in bits 31:24. The constant starts at 0x01 and is multiplied by x in GF(2^8) modulo x^8+x^4+x^3+x+1 after each use. When Nk = 8 and i mod Nk = 4, t is the byte substitution of word(i−1). The substitution of a byte is the affine map (constant 0x63) applied to its multiplicative inverse. Example: with key 2b7e1516 28aed2a6 abf71588 09cf4f3c and Nk = Nb = 4, word 43 is b6630ca6.
- R5: One word is produced per clock. `busy` is high from the edge that accepts `start` for exactly Nb·(Nr+1) further edges. On the edge that writes the last word, `busy` falls and `done` rises.
- R6: While `busy` is high, `start` and `key_we` have no effect. The sizes in use, the round count and the key being expanded stay as they were.
- R7: A forward read (`rd_en` = 1, `rd_decrypt` = 0, `rd_round` = r ≤ Nr) returns expanded words r·Nb + j in bits 32j+31:32j of `rd_key`, for j < Nb. The result is shown on the next edge with `rd_valid` high. After a cycle without `rd_en`, `rd_valid` is low.
- R8: A reverse read (`rd_decrypt` = 1) of index r ≤ Nr returns the key that a forward read of Nr − r returns, with the same latency.
- R9: Slots j ≥ Nb of `rd_key` are zero. Any read with `rd_round` > Nr returns an all-zero key.
- R10: `done` stays high until the next accepted `start`, and that start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Write one cipher-key word |
| key_idx | input | 3 | Key slot written by `key_we` |
| key_word | input | 32 | Key word data, byte 0 in bits 31:24 |
| nk_code | input | 2 | Cipher key size code |
| nb_code | input | 2 | Block size code |
| start | input | 1 | Begin expansion |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | Full schedule stored |
| rounds | output | 4 | Round count of the current schedule |
| rd_en | input | 1 | Round-key read request |
| rd_round | input | 4 | Requested round index |
| rd_decrypt | input | 1 | 1 selects the mirrored index Nr − r |
| rd_valid | output | 1 | `rd_key` holds a fresh result |
| rd_key | output | 256 | Round key, slot j in bits 32j+31:32j |

## Verification
The expansion runs under seven size pairings. Square cases (4/4, 8/8 reached through code 3) are set against mixed ones where the key is narrower than the block (4/6, 4/8, 6/8) or wider (6/4, 8/4). This separates errors in the word-stride and round-count arithmetic from errors in the recurrence, whose rotate, half-way substitution and constant steps fall at different points of each round key. A published 128-bit key gives one absolute anchor. Every round is read in both directions, and so is one index past the last. This checks the mirror and the zero fill. One 8/4 run writes a key word and re-issues `start` in the middle of the expansion, to show that neither one reaches the stored schedule.

// File: rtl/keysched_pkg.sv
package keysched_pkg;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 gives the inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int k = 0; k < 7; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^ b[(i + 6) % 8] ^ b[(i + 7) % 8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    return affine(gf_inv(a));
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [3:0] size_from_code(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] rounds_for(input logic [3:0] nk, input logic [3:0] nb);
    return ((nk > nb) ? nk : nb) + 4'd6;
  endfunction

endpackage

// File: rtl/ks_expand.sv
module ks_expand
  import keysched_pkg::*;
#(
  parameter int MAX_NK = 8,
  parameter int ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_we,
  input  logic [$clog2(MAX_NK)-1:0] key_idx,
  input  logic [31:0]               key_word,
  input  logic                      start,
  input  logic [1:0]                nk_code,
  input  logic [1:0]                nb_code,
  output logic                      busy,
  output logic                      done,
  output logic [3:0]                nb_q,
  output logic [3:0]                nr_q,
  output logic                      wr_en,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [31:0]               wr_data
);
  localparam int IDX_W = $clog2(MAX_NK);

  logic [31:0]       key_q [MAX_NK];
  logic [31:0]       win   [MAX_NK];
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] total_q;
  logic [IDX_W-1:0]  phase;
  logic [7:0]        rcon;
  logic [3:0]        nk_q;
  logic [3:0]        nk_n, nb_n, nr_n;
  logic [ADDR_W:0]   total_n;
  logic              accept, last_word, from_key, rot_step, half_step;
  logic [31:0]       prev_w, back_w, sub_in, sub_out, temp_w, next_w;

  always_comb begin
    nk_n      = size_from_code(nk_code);
    nb_n      = size_from_code(nb_code);
    nr_n      = rounds_for(nk_n, nb_n);
    total_n   = (ADDR_W+1)'(nb_n) * (ADDR_W+1)'(nr_n + 4'd1);
    accept    = start && !busy;
    last_word = busy && (cnt == total_q - 1'b1);
    from_key  = cnt < ADDR_W'(nk_q);
    prev_w    = win[0];
    back_w    = win[IDX_W'(nk_q - 4'd1)];
    rot_step  = (phase == '0);
    half_step = (nk_q == 4'd8) && (phase == IDX_W'(4));
    sub_in    = rot_step ? {prev_w[23:0], prev_w[31:24]} : prev_w;
    sub_out   = sub_word(sub_in);
    temp_w    = rot_step ? (sub_out ^ {rcon, 24'h000000})
              : (half_step ? sub_out : prev_w);
    next_w    = from_key ? key_q[cnt[IDX_W-1:0]] : (back_w ^ temp_w);
    wr_en     = busy;
    wr_addr   = cnt;
    wr_data   = next_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_NK; k++) key_q[k] <= '0;
    end else if (key_we && !busy) begin
      key_q[key_idx] <= key_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      total_q <= '0;
      phase   <= '0;
      rcon    <= 8'h01;
      nk_q    <= 4'd4;
      nb_q    <= 4'd4;
      nr_q    <= 4'd10;
      for (int k = 0; k < MAX_NK; k++) win[k] <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
      phase   <= '0;
      rcon    <= 8'h01;
      nk_q    <= nk_n;
      nb_q    <= nb_n;
      nr_q    <= nr_n;
      total_q <= total_n[ADDR_W-1:0];
    end else if (busy) begin
      cnt   <= cnt + 1'b1;
      phase <= (phase == IDX_W'(nk_q - 4'd1)) ? '0 : phase + 1'b1;
      if (!from_key && rot_step) rcon <= gf_xtime(rcon);
      win[0] <= next_w;
      for (int k = 1; k < MAX_NK; k++) win[k] <= win[k-1];
      if (last_word) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R5
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_word |=> busy && (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  // R5
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> done && !busy);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_word |=> $stable(nb_q) && $stable(nr_q) && $stable(nk_q));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

endmodule

// File: rtl/ks_store.sv
module ks_store #(
  parameter int DEPTH    = 120,
  parameter int ADDR_W   = 7,
  parameter int RD_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic [ADDR_W-1:0]        rd_base,
  output logic [RD_WORDS*32-1:0]   rd_words
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar j = 0; j < RD_WORDS; j++) begin : g_rd
    logic [ADDR_W:0] addr_j;
    assign addr_j = {1'b0, rd_base} + (ADDR_W+1)'(j);
    assign rd_words[j*32 +: 32] = (addr_j < (ADDR_W+1)'(DEPTH)) ? mem[addr_j[ADDR_W-1:0]] : '0;
  end

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < (ADDR_W+1)'(DEPTH)));

endmodule

// File: rtl/ks_select.sv
module ks_select #(
  parameter int MAX_NB = 8,
  parameter int ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [3:0]             rd_round,
  input  logic                   rd_decrypt,
  input  logic [3:0]             nb,
  input  logic [3:0]             nr,
  input  logic [MAX_NB*32-1:0]   words_in,
  output logic [ADDR_W-1:0]      rd_base,
  output logic                   rd_valid,
  output logic [MAX_NB*32-1:0]   rd_key
);
  logic            in_range;
  logic [3:0]      eff;
  logic [ADDR_W:0] base_full;
  logic [MAX_NB*32-1:0] masked;

  always_comb begin
    in_range  = rd_round <= nr;
    eff       = rd_decrypt ? (nr - rd_round) : rd_round;
    base_full = (ADDR_W+1)'(eff) * (ADDR_W+1)'(nb);
    rd_base   = in_range ? base_full[ADDR_W-1:0] : '0;
  end

  for (genvar j = 0; j < MAX_NB; j++) begin : g_mask
    assign masked[j*32 +: 32] = (in_range && (nb > 4'(j))) ? words_in[j*32 +: 32] : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_key   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_key <= masked;
    end
  end

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R7
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9
  oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !in_range |=> (rd_key == '0));

endmodule

// File: rtl/keysched_top.sv
module keysched_top #(
  parameter int MAX_NK = 8,
  parameter int MAX_NB = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_we,
  input  logic [$clog2(MAX_NK)-1:0] key_idx,
  input  logic [31:0]               key_word,
  input  logic [1:0]                nk_code,
  input  logic [1:0]                nb_code,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic [3:0]                rounds,
  input  logic                      rd_en,
  input  logic [3:0]                rd_round,
  input  logic                      rd_decrypt,
  output logic                      rd_valid,
  output logic [MAX_NB*32-1:0]      rd_key
);
  localparam int MAX_NR = ((MAX_NK > MAX_NB) ? MAX_NK : MAX_NB) + 6;
  localparam int DEPTH  = MAX_NB * (MAX_NR + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [ADDR_W-1:0] rd_base;
  logic [MAX_NB*32-1:0] words;
  logic [3:0]        nb_q;
  logic [3:0]        nr_q;

  ks_expand #(.MAX_NK(MAX_NK), .ADDR_W(ADDR_W)) u_expand (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx), .key_word(key_word),
    .start(start), .nk_code(nk_code), .nb_code(nb_code), .busy(busy), .done(done),
    .nb_q(nb_q), .nr_q(nr_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ks_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RD_WORDS(MAX_NB)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_base(rd_base), .rd_words(words)
  );

  ks_select #(.MAX_NB(MAX_NB), .ADDR_W(ADDR_W)) u_select (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_round(rd_round), .rd_decrypt(rd_decrypt),
    .nb(nb_q), .nr(nr_q), .words_in(words), .rd_base(rd_base), .rd_valid(rd_valid),
    .rd_key(rd_key)
  );

  assign rounds = nr_q;

endmodule

// File: tb/keysched_top_test.sv
module keysched_top_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, key_we, start, rd_en, rd_decrypt;
  logic [2:0]   key_idx;
  logic [31:0]  key_word;
  logic [1:0]   nk_code, nb_code;
  logic [3:0]   rd_round;
  logic         busy, done, rd_valid;
  logic [3:0]   rounds;
  logic [255:0] rd_key;

  keysched_top uut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx), .key_word(key_word),
    .nk_code(nk_code), .nb_code(nb_code), .start(start), .busy(busy), .done(done),
    .rounds(rounds), .rd_en(rd_en), .rd_round(rd_round), .rd_decrypt(rd_decrypt),
    .rd_valid(rd_valid), .rd_key(rd_key)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0]  sb [256];
  logic [31:0] expw [120];
  logic [31:0] keyv [8];

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    int p = 0;
    int x = a;
    int y = b;
    while (y != 0) begin
      if ((y & 1) != 0) p = p ^ x;
      x = x << 1;
      if ((x & 'h100) != 0) x = x ^ 'h11b;
      y = y >> 1;
    end
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl8(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      sb[a] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [31:0] subw(logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic int sz(int code);
    return (code == 0) ? 4 : ((code == 1) ? 6 : 8);
  endfunction

  task automatic model(int nk, int nb);
    int nr = ((nk > nb) ? nk : nb) + 6;
    int total = nb * (nr + 1);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < nk; i++) expw[i] = keyv[i];
    for (int i = nk; i < total; i++) begin
      logic [31:0] t = expw[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) begin
        t = subw(t);
      end
      expw[i] = expw[i-nk] ^ t;
    end
  endtask

  function automatic logic [255:0] exp_key(int r, bit dec, int nb, int nr);
    logic [255:0] v = '0;
    int e;
    if (r > nr) return v;
    e = dec ? nr - r : r;
    for (int j = 0; j < nb; j++) v[j*32 +: 32] = expw[e*nb + j];
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(int nkc, int nbc, bit glitch, bit known);
    int nk = sz(nkc);
    int nb = sz(nbc);
    int nr = ((nk > nb) ? nk : nb) + 6;
    int total = nb * (nr + 1);
    model(nk, nb);
    for (int k = 0; k < nk; k++) begin
      @(negedge clk);
      key_we = 1'b1; key_idx = 3'(k); key_word = keyv[k];
    end
    @(negedge clk);
    key_we = 1'b0;
    nk_code = 2'(nkc); nb_code = 2'(nbc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 round count
    check(rounds == 4'(nr), "R2", "rounds", 256'(rounds), 256'(nr));
    for (int s = 0; s <= total; s++) begin
      // R5 per-cycle busy/done, R10 start clears done
      check(busy == (s < total), "R5", $sformatf("busy s=%0d", s), 256'(busy), 256'(s < total));
      check(done == (s == total), "R10", $sformatf("done s=%0d", s), 256'(done), 256'(s == total));
      if (glitch && s == 2) begin
        key_we = 1'b1; key_idx = 3'(nk - 1); key_word = 32'hdeadbeef;
      end
      if (glitch && s == 3) begin
        key_we = 1'b0; start = 1'b1; nk_code = 2'd0; nb_code = 2'd2;
      end
      if (glitch && s == 4) start = 1'b0;
      if (s < total) @(negedge clk);
    end
    if (glitch) check(rounds == 4'(nr), "R6", "rounds after ignored start", 256'(rounds), 256'(nr));
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R10", "done held", 256'(done), 256'(1));
    for (int r = 0; r <= nr + 1; r++) begin
      for (int d = 0; d < 2; d++) begin
        logic [255:0] e = exp_key(r, d[0], nb, nr);
        rd_en = 1'b1; rd_round = 4'(r); rd_decrypt = d[0];
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid == 1'b1, "R7", "rd_valid", 256'(rd_valid), 256'(1));
        if (r > nr)      check(rd_key == e, "R9", $sformatf("oob r=%0d d=%0d", r, d), rd_key, e);
        else if (d == 1) check(rd_key == e, "R8", $sformatf("reverse r=%0d", r), rd_key, e);
        else             check(rd_key == e, "R7", $sformatf("forward r=%0d", r), rd_key, e);
        if (glitch) check(rd_key == e, "R6", "schedule unaffected", rd_key, e);
        if (r == 0 && d == 0)
          for (int j = 0; j < nk && j < nb; j++)
            check(rd_key[j*32 +: 32] == keyv[j], "R3", $sformatf("key word %0d", j),
                  256'(rd_key[j*32 +: 32]), 256'(keyv[j]));
        @(negedge clk);
        check(rd_valid == 1'b0, "R7", "rd_valid idle", 256'(rd_valid), 256'(0));
      end
    end
    if (known) begin
      rd_en = 1'b1; rd_round = 4'd10; rd_decrypt = 1'b0;
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_key[127:96] == 32'hb6630ca6, "R4", "known word 43", 256'(rd_key[127:96]), 256'(32'hb6630ca6));
    end
  endtask

  task automatic set_key(int seed);
    for (int k = 0; k < 8; k++) keyv[k] = 32'(seed) * 32'h9e3779b9 + 32'(k) * 32'h7f4a7c15 ^ 32'h5a5a0f0f;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; key_we = 1'b0; start = 1'b0; rd_en = 1'b0; rd_decrypt = 1'b0;
    key_idx = '0; key_word = '0; nk_code = '0; nb_code = '0; rd_round = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && !done && !rd_valid, "R1", "in reset", 256'({busy, done, rd_valid}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_valid, "R1", "after reset", 256'({busy, done, rd_valid}), 256'(0));

    keyv[0] = 32'h2b7e1516; keyv[1] = 32'h28aed2a6; keyv[2] = 32'habf71588; keyv[3] = 32'h09cf4f3c;
    run_case(0, 0, 1'b0, 1'b1);
    set_key(3);  run_case(1, 0, 1'b0, 1'b0);
    set_key(7);  run_case(2, 0, 1'b1, 1'b0);
    set_key(11); run_case(0, 1, 1'b0, 1'b0);
    set_key(19); run_case(0, 2, 1'b0, 1'b0);
    set_key(23); run_case(2, 3, 1'b0, 1'b0);
    set_key(29); run_case(1, 2, 1'b0, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule